// File: doc/BRIEF.md
# Programmable Multi-Mode Serial Clock Timing Generator

This block turns a fast function clock into a serial bus clock for three kinds of traffic. The first is fast push-pull signalling. The second is slower open-drain signalling. The third is legacy two-wire transfers. Each phase length is built from nested counting layers:

- A base unit of function-clock cycles.
- A number of base units that make up one open-drain half-period.
- A number of open-drain half-periods that make up one legacy phase.

An optional short-high setting makes the open-drain clock asymmetric. It keeps the long low phase and cuts the high phase to a single base unit.

A controller raises `run_i` to start clocking and lowers it to park the bus clock high. Two one-cycle strobes tell the protocol logic where it may change data and where it should sample data. The fall strobe marks the start of each low phase, and the rise strobe marks the start of each high phase. Configuration is captured at the start of every period, so the controller may change it at any time without creating a malformed phase.

Top module: `scl_timing_gen`

## Requirements
- R1: While `run_i` is low, or in reset, `scl_o` is 1 and both strobes are 0. The first cycle after `run_i` is sampled high starts a low phase with `fall_stb_o` set, so every run begins with a full low phase.
- R2: With `mode_i`=0 (push-pull), the low phase lasts 1+`pp_div_i`+`pp_lowext_i` cycles and the high phase lasts 1+`pp_div_i` cycles. For example, `pp_div_i`=1 gives a 4-cycle period, which is 12.5 MHz from 50 MHz.
- R3: With `mode_i`=1 (open-drain) and `od_shorthi_i`=0, both phases last (`od_mult_i`+1)·(1+`pp_div_i`) cycles. `pp_lowext_i` has no effect.
- R4: With `mode_i`=1 and `od_shorthi_i`=1, the low phase lasts (`od_mult_i`+1)·(1+`pp_div_i`) cycles and the high phase lasts 1+`pp_div_i` cycles. `pp_lowext_i` has no effect.
- R5: With `mode_i`=2 or 3 (legacy), the phase lengths are counted in open-drain half-periods H=(`od_mult_i`+1)·(1+`pp_div_i`). The low phase is (ceil(`i2c_span_i`/2)+1)·H cycles and the high phase is (floor(`i2c_span_i`/2)+1)·H cycles. `pp_lowext_i` and `od_shorthi_i` have no effect.
- R6: `fall_stb_o` is high for exactly the first cycle of each low phase (`scl_o`=0). `rise_stb_o` is high for exactly the first cycle of each high phase (`scl_o`=1). The two strobes are never high together, and `scl_o` never falls without `fall_stb_o`.
- R7: Configuration inputs are sampled only in the cycle before a low phase begins, whether the clock is starting from idle or continuing from a high phase. A change made during a period takes effect at the next period and never alters the phases already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Function clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Enables clocking; low holds the bus clock high |
| mode_i | input | 2 | 0 push-pull, 1 open-drain, 2 or 3 legacy |
| pp_div_i | input | PPB_W | Base unit minus one, in function-clock cycles |
| pp_lowext_i | input | PPL_W | Extra low cycles in push-pull mode |
| od_mult_i | input | ODB_W | Base units per open-drain half-period, minus one |
| od_shorthi_i | input | 1 | Open-drain high phase shortened to one base unit |
| i2c_span_i | input | I2B_W | Legacy phase length selector, in open-drain half-periods |
| scl_o | output | 1 | Generated bus clock |
| rise_stb_o | output | 1 | One-cycle marker at the start of each high phase |
| fall_stb_o | output | 1 | One-cycle marker at the start of each low phase |

## Verification
The hardest case to reach from the ports is a configuration change that lands inside a running period. It has to prove that capture happens only at the period boundary. The stimulus starts a slow push-pull clock and rewrites the divider one cycle into the low phase. It then measures that the current low and high phases keep the old lengths and that the following period uses the new ones. Long nested products, such as a 21-unit open-drain half-period of 4 cycles, exercise the carry between counting layers. The odd and even legacy spans exercise the uneven high/low split.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

   typedef enum logic [1:0] {
      MODE_PP      = 2'd0,
      MODE_OD      = 2'd1,
      MODE_LEGACY  = 2'd2,
      MODE_LEGACY2 = 2'd3
   } scl_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOW  = 2'd1,
      ST_HIGH = 2'd2
   } scl_state_e;

   localparam int NUM_LAYERS = 3;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/scl_len_calc.sv
module scl_len_calc
   import scl_timing_pkg::*;
#(
   parameter int PPB_W = 4,
   parameter int PPL_W = 4,
   parameter int ODB_W = 8,
   parameter int I2B_W = 4,
   parameter int CNT_W = 9
) (
   input  scl_mode_e                            mode,
   input  logic                                 phase_hi,
   input  logic [PPB_W-1:0]                     pp_div,
   input  logic [PPL_W-1:0]                     pp_lowext,
   input  logic [ODB_W-1:0]                     od_mult,
   input  logic                                 od_shorthi,
   input  logic [I2B_W-1:0]                     i2c_span,
   output logic [NUM_LAYERS-1:0][CNT_W-1:0]     len_o
);

   logic             is_pp;
   logic             is_od;
   logic             is_legacy;
   logic [CNT_W-1:0] base_len;
   logic [CNT_W-1:0] ext_len;
   logic [CNT_W-1:0] od_len;
   logic [CNT_W-1:0] span_lo;
   logic [CNT_W-1:0] span_hi;

   always_comb begin
      is_pp     = (mode == MODE_PP);
      is_od     = (mode == MODE_OD);
      is_legacy = (mode == MODE_LEGACY) || (mode == MODE_LEGACY2);

      // layer 0: function-clock cycles per base unit (low extension only in push-pull)
      base_len = CNT_W'(pp_div) + CNT_W'(1);
      ext_len  = (is_pp && !phase_hi) ? CNT_W'(pp_lowext) : '0;
      len_o[0] = base_len + ext_len;

      // layer 1: base units per open-drain half-period
      od_len = CNT_W'(od_mult) + CNT_W'(1);
      if (is_pp)
         len_o[1] = CNT_W'(1);
      else if (is_od && phase_hi && od_shorthi)
         len_o[1] = CNT_W'(1);
      else
         len_o[1] = od_len;

      // layer 2: open-drain half-periods per legacy phase
      span_hi = (CNT_W'(i2c_span) >> 1) + CNT_W'(1);
      span_lo = ((CNT_W'(i2c_span) + CNT_W'(1)) >> 1) + CNT_W'(1);
      if (is_legacy)
         len_o[2] = phase_hi ? span_hi : span_lo;
      else
         len_o[2] = CNT_W'(1);
   end

endmodule

// File: rtl/scl_layer_cnt.sv
module scl_layer_cnt #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic [CNT_W-1:0] len,
   output logic             wrap
);

   logic [CNT_W-1:0] cnt_q;

   assign wrap = step && (cnt_q == (len - CNT_W'(1)));

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (step)
         cnt_q <= wrap ? '0 : (cnt_q + CNT_W'(1));
   end

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
   import scl_timing_pkg::*;
#(
   parameter int PPB_W = 4,
   parameter int PPL_W = 4,
   parameter int ODB_W = 8,
   parameter int I2B_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [1:0]       mode_i,
   input  logic [PPB_W-1:0] pp_div_i,
   input  logic [PPL_W-1:0] pp_lowext_i,
   input  logic [ODB_W-1:0] od_mult_i,
   input  logic             od_shorthi_i,
   input  logic [I2B_W-1:0] i2c_span_i,
   output logic             scl_o,
   output logic             rise_stb_o,
   output logic             fall_stb_o
);

   localparam int L0_W  = max_of(PPB_W, PPL_W) + 1;
   localparam int L1_W  = ODB_W + 1;
   localparam int L2_W  = I2B_W + 1;
   localparam int CNT_W = max_of(L0_W, max_of(L1_W, L2_W));

   if (PPB_W < 1 || PPL_W < 1) begin : g_bad_pp
      $error("push-pull field widths must be at least 1");
   end
   if (ODB_W < 1 || I2B_W < 1) begin : g_bad_od
      $error("open-drain and legacy field widths must be at least 1");
   end

   // captured configuration
   scl_mode_e        mode_q;
   logic [PPB_W-1:0] pp_div_q;
   logic [PPL_W-1:0] pp_lowext_q;
   logic [ODB_W-1:0] od_mult_q;
   logic             od_shorthi_q;
   logic [I2B_W-1:0] i2c_span_q;

   scl_state_e       state_q;
   logic             rise_q;
   logic             fall_q;

   logic [NUM_LAYERS-1:0][CNT_W-1:0] layer_len;
   logic [NUM_LAYERS-1:0]            layer_step;
   logic [NUM_LAYERS-1:0]            layer_wrap;
   logic                             counting;
   logic                             cnt_clr;
   logic                             phase_end;
   logic                             cfg_load;

   assign counting  = run_i && (state_q != ST_IDLE);
   assign cnt_clr   = !run_i || (state_q == ST_IDLE);
   assign phase_end = layer_wrap[NUM_LAYERS-1];
   assign cfg_load  = (state_q == ST_IDLE) || ((state_q == ST_HIGH) && phase_end);

   scl_len_calc #(
      .PPB_W (PPB_W),
      .PPL_W (PPL_W),
      .ODB_W (ODB_W),
      .I2B_W (I2B_W),
      .CNT_W (CNT_W)
   ) u_len (
      .mode       (mode_q),
      .phase_hi   (state_q == ST_HIGH),
      .pp_div     (pp_div_q),
      .pp_lowext  (pp_lowext_q),
      .od_mult    (od_mult_q),
      .od_shorthi (od_shorthi_q),
      .i2c_span   (i2c_span_q),
      .len_o      (layer_len)
   );

   for (genvar g = 0; g < NUM_LAYERS; g++) begin : g_layer
      if (g == 0) begin : g_first
         assign layer_step[g] = counting;
      end else begin : g_chain
         assign layer_step[g] = layer_wrap[g-1];
      end

      scl_layer_cnt #(
         .CNT_W (CNT_W)
      ) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (cnt_clr),
         .step  (layer_step[g]),
         .len   (layer_len[g]),
         .wrap  (layer_wrap[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q       <= MODE_PP;
         pp_div_q     <= '0;
         pp_lowext_q  <= '0;
         od_mult_q    <= '0;
         od_shorthi_q <= 1'b0;
         i2c_span_q   <= '0;
      end else if (cfg_load) begin
         mode_q       <= scl_mode_e'(mode_i);
         pp_div_q     <= pp_div_i;
         pp_lowext_q  <= pp_lowext_i;
         od_mult_q    <= od_mult_i;
         od_shorthi_q <= od_shorthi_i;
         i2c_span_q   <= i2c_span_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rise_q  <= 1'b0;
         fall_q  <= 1'b0;
      end else if (!run_i) begin
         state_q <= ST_IDLE;
         rise_q  <= 1'b0;
         fall_q  <= 1'b0;
      end else begin
         rise_q <= 1'b0;
         fall_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               state_q <= ST_LOW;
               fall_q  <= 1'b1;
            end
            ST_LOW: begin
               if (phase_end) begin
                  state_q <= ST_HIGH;
                  rise_q  <= 1'b1;
               end
            end
            ST_HIGH: begin
               if (phase_end) begin
                  state_q <= ST_LOW;
                  fall_q  <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign scl_o      = (state_q != ST_LOW);
   assign rise_stb_o = rise_q;
   assign fall_stb_o = fall_q;

endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk (
   input logic clk,
   input logic rst_n,
   input logic run_i,
   input logic scl_o,
   input logic rise_stb_o,
   input logic fall_stb_o
);

   assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_stb_o && fall_stb_o));

   assert_rise_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rise_stb_o |-> scl_o);

   assert_fall_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fall_stb_o |-> !scl_o);

   assert_fall_marked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scl_o) |-> fall_stb_o);

   assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> scl_o);

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> !(rise_stb_o || fall_stb_o));

endmodule

bind scl_timing_gen scl_timing_gen_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .run_i      (run_i),
   .scl_o      (scl_o),
   .rise_stb_o (rise_stb_o),
   .fall_stb_o (fall_stb_o)
);

// File: tb/scl_timing_gen_tb_top.sv
`timescale 1ns/1ps
module scl_timing_gen_tb_top;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       run_i;
   logic [1:0] mode_i;
   logic [3:0] pp_div_i;
   logic [3:0] pp_lowext_i;
   logic [7:0] od_mult_i;
   logic       od_shorthi_i;
   logic [3:0] i2c_span_i;
   logic       scl_o;
   logic       rise_stb_o;
   logic       fall_stb_o;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   scl_timing_gen dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .run_i        (run_i),
      .mode_i       (mode_i),
      .pp_div_i     (pp_div_i),
      .pp_lowext_i  (pp_lowext_i),
      .od_mult_i    (od_mult_i),
      .od_shorthi_i (od_shorthi_i),
      .i2c_span_i   (i2c_span_i),
      .scl_o        (scl_o),
      .rise_stb_o   (rise_stb_o),
      .fall_stb_o   (fall_stb_o)
   );

   typedef struct packed {
      int req;
      int mode;
      int pb;
      int pl;
      int od;
      int hpp;
      int sp;
      int lo;
      int hi;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{2, 0, 0,  0,  0, 0, 0,  1,  1},   // R2 fastest
      '{2, 0, 1,  0,  0, 0, 0,  2,  2},   // R2 4-cycle period
      '{2, 0, 2,  3,  0, 0, 0,  6,  3},   // R2 low extension
      '{2, 0, 0, 15,  0, 1, 0, 16,  1},   // R2 max extension
      '{3, 1, 1,  0,  4, 0, 0, 10, 10},   // R3 symmetric
      '{3, 1, 0,  5,  2, 0, 0,  3,  3},   // R3 extension ignored
      '{3, 1, 3,  0, 20, 0, 0, 84, 84},   // R3 long product
      '{4, 1, 1,  0,  4, 1, 0, 10,  2},   // R4 short high
      '{4, 1, 2,  2,  1, 1, 0,  6,  3},   // R4 extension ignored
      '{5, 2, 0,  0,  1, 0, 3,  6,  4},   // R5 odd span
      '{5, 2, 0,  0,  1, 0, 4,  6,  6},   // R5 even span
      '{5, 2, 1,  7,  0, 1, 0,  2,  2},   // R5 zero span, extras ignored
      '{5, 2, 0,  0,  0, 0, 5,  4,  3},   // R5 span five
      '{5, 3, 0,  0,  0, 0, 1,  2,  1}    // R5 alternate code
   };

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      mode_i       = 2'(v.mode);
      pp_div_i     = 4'(v.pb);
      pp_lowext_i  = 4'(v.pl);
      od_mult_i    = 8'(v.od);
      od_shorthi_i = v.hpp[0];
      i2c_span_i   = 4'(v.sp);
   endtask

   // Called right after a sample showing fall_stb_o; returns at the next fall sample.
   task automatic measure_from_fall(output int lo, output int hi, output bit shape_ok);
      lo = 1;
      hi = 0;
      shape_ok = 1'b1;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (rise_stb_o) break;
         if (scl_o || fall_stb_o) shape_ok = 1'b0;
         lo++;
      end
      if (!scl_o) shape_ok = 1'b0;
      hi = 1;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (fall_stb_o) break;
         if (!scl_o || rise_stb_o) shape_ok = 1'b0;
         hi++;
      end
      if (scl_o) shape_ok = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      int  lo;
      int  hi;
      bit  ok;
      string tag;

      rst_n = 1'b0;
      run_i = 1'b0;
      apply(VECS[0]);
      repeat (4) @(negedge clk);
      // R1 reset state
      check(scl_o && !rise_stb_o && !fall_stb_o, "R1", "reset outputs",
            {29'd0, scl_o, rise_stb_o, fall_stb_o}, 4);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(scl_o && !rise_stb_o && !fall_stb_o, "R1", "idle outputs",
            {29'd0, scl_o, rise_stb_o, fall_stb_o}, 4);

      for (int n = 0; n < NV; n++) begin
         tag = $sformatf("R%0d", VECS[n].req);
         apply(VECS[n]);
         @(negedge clk);
         run_i = 1'b1;
         @(negedge clk);
         // R1 and R6: low phase with fall strobe one cycle after start
         check(fall_stb_o && !scl_o, "R1", "first fall strobe", int'(fall_stb_o), 1);
         measure_from_fall(lo, hi, ok);
         check(ok, "R6", "strobe and level shape", int'(ok), 1);
         check(lo == VECS[n].lo, tag, $sformatf("low length vec %0d", n), lo, VECS[n].lo);
         check(hi == VECS[n].hi, tag, $sformatf("high length vec %0d", n), hi, VECS[n].hi);
         run_i = 1'b0;
         @(negedge clk);
         check(scl_o && !rise_stb_o && !fall_stb_o, "R1", "stop parks high",
               int'(scl_o), 1);
      end

      // R7: change configuration mid-period
      apply('{7, 0, 3, 0, 0, 0, 0, 0, 0});
      @(negedge clk);
      run_i = 1'b1;
      @(negedge clk);
      check(fall_stb_o, "R7", "start fall", int'(fall_stb_o), 1);
      pp_div_i = 4'd0;
      measure_from_fall(lo, hi, ok);
      check(lo == 4 && hi == 4 && ok, "R7", "old period kept (low)", lo, 4);
      check(hi == 4, "R7", "old period kept (high)", hi, 4);
      measure_from_fall(lo, hi, ok);
      check(lo == 1 && hi == 1 && ok, "R7", "new period applied (low)", lo, 1);
      check(hi == 1, "R7", "new period applied (high)", hi, 1);

      // R1: disable in the middle of a low phase, config changes while idle ignored
      pp_div_i = 4'd5;
      @(negedge clk);
      @(negedge clk);
      run_i = 1'b0;
      pp_div_i = 4'd2;
      mode_i = 2'd1;
      ok = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (!scl_o || rise_stb_o || fall_stb_o) ok = 1'b0;
      end
      check(ok, "R1", "held high while stopped", int'(ok), 1);

      // R1: restart begins with a fresh low phase using the new config
      mode_i = 2'd0;
      pp_div_i = 4'd2;
      pp_lowext_i = 4'd0;
      run_i = 1'b1;
      @(negedge clk);
      check(fall_stb_o && !scl_o, "R1", "restart fall", int'(fall_stb_o), 1);
      measure_from_fall(lo, hi, ok);
      check(lo == 3 && ok, "R1", "restart low from zero", lo, 3);
      check(hi == 3, "R2", "restart high", hi, 3);
      run_i = 1'b0;
      @(negedge clk);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule